// File: doc/BRIEF.md
# Indirect-Access Interrupt Redirection Controller

This block routes a set of interrupt input levels to interrupt messages. Each input has its own 64-bit routing entry that holds a vector, a destination, a mask, a trigger mode, a destination mode and a delivery mode. The block watches every input for a low-to-high change. When an input rises and its entry allows delivery, the block emits a message that carries the vector and the destination, with a broadcast flag when the destination is the all-ones value. Messages leave through a valid/ready port. When several inputs need service at once, the lowest-numbered input goes first.

Software reaches all the state through two 32-bit memory-mapped locations. The first holds an index. The second is a window onto the register that the index names: an identity register, a read-only version word, a read-only arbitration word that mirrors the identity, and the routing table. Each table entry spans two window indices. An input that rises while its entry is masked and level-triggered is remembered as pending. That event is replayed when software later unmasks the entry, but only if the input is still high.

Top module: `irq_redir_ctrl`

## Requirements
- R1: After reset, every routing entry reads 0x0001_0000 in its low half and 0x0001_0000 in its high half, so all inputs are masked. The index register reads 0 and `msg_valid` is low.
- R2: The block decodes only bus offset 0x00 (index) and 0x10 (window), and only for 4-byte accesses. Any other offset or size reads as 0 and is ignored on write. A read returns its data with `bus_rvalid` one cycle after the request.
- R3: A write to offset 0x00 stores the full 32-bit value and changes nothing else. A read of offset 0x00 returns the stored value. Only bits 7:0 of that value choose the window register.
- R4: Window index 0x00 is the identity register, and a write to it keeps only bits 27:24. Index 0x02 reads the same value as index 0x00 and ignores writes.
- R5: Window index 0x01 reads 0x0010_0011 (the entry count 16 at bit 16, ORed with 0x11) and ignores writes.
- R6: Entry n sits at window indices 0x10+2n (bits 31:0) and 0x11+2n (bits 63:32). A write to one half leaves the other half unchanged. Indices from 0x30 to 0xFF, and 0x03 to 0x0F, read as 0.
- R7: A message is sent only after a low-to-high change of an input whose entry is unmasked (bit 16 = 0), in physical destination mode (bit 11 = 0) and in fixed delivery mode (bits 10:8 = 000). The message vector is entry bits 7:0 and the destination is bits 63:56. A high-to-low change sends nothing.
- R8: `msg_bcast` is 1 exactly when the destination is 0xFF.
- R9: A rise on an input whose entry is masked and level-triggered (bit 15 = 1) sets a pending event and sends nothing. A later write that leaves the entry unmasked clears the pending event. The message is then sent if the input is still high, and is dropped if the input is low.
- R10: A rise on a masked edge-triggered input (bit 15 = 0) is dropped. Unmasking its entry later sends nothing.
- R11: When several messages wait, the lowest-numbered input is offered first. An offered message keeps its valid, vector, destination and broadcast values until `msg_ready` accepts it.
- R12: A rise on an unmasked input whose entry selects logical destination mode (bit 11 = 1) or a non-fixed delivery mode sends nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Bus request strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset within the block |
| bus_size | input | 3 | Access size in bytes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data |
| bus_rvalid | output | 1 | Read data valid, one cycle after a read request |
| irq_in | input | 16 | Interrupt input levels, one bit per input |
| msg_valid | output | 1 | Interrupt message offered |
| msg_ready | input | 1 | Message accepted |
| msg_vector | output | 8 | Message vector |
| msg_dest | output | 8 | Message destination |
| msg_bcast | output | 1 | Message goes to all enabled CPUs |

## Verification
The bench builds the block with its default parameters: 16 inputs and an 8-bit bus offset. This puts the whole table in range, from index 0x10 up to the last odd index 0x2F, along with the out-of-table indices on both sides of it. With 16 inputs, two inputs can rise in the same cycle while the output is held back, so the lowest-first order and the hold of an offered message can both be observed. The pending path is driven to both outcomes, the input still high at unmask and the input already low, and the results are read only at the message port.

// File: rtl/irq_redir_pkg.sv
package irq_redir_pkg;

    // Bus offsets and access size
    localparam logic [7:0] OFFS_INDEX  = 8'h00;
    localparam logic [7:0] OFFS_WINDOW = 8'h10;
    localparam int         ACC_BYTES   = 4;

    // Window index map
    localparam logic [7:0] IDX_IDENT = 8'h00;
    localparam logic [7:0] IDX_VERS  = 8'h01;
    localparam logic [7:0] IDX_ARBW  = 8'h02;
    localparam logic [7:0] IDX_TBASE = 8'h10;

    // Identity field kept on write
    localparam int IDENT_LSB = 24;
    localparam int IDENT_W   = 4;

    // Routing entry field positions
    localparam int BIT_MASK  = 16;
    localparam int BIT_LEVEL = 15;
    localparam int BIT_LOGIC = 11;
    localparam int DLV_LSB   = 8;
    localparam int DEST_LSB  = 56;

    localparam logic [7:0]  VERS_CODE   = 8'h11;
    localparam logic [7:0]  BCAST_DEST  = 8'hFF;
    localparam logic [63:0] ENTRY_RESET = 64'h0001_0000_0001_0000;

    typedef struct packed {
        logic [7:0] vector;
        logic [7:0] dest;
    } irq_msg_t;

    function automatic logic entry_masked(input logic [63:0] e);
        return e[BIT_MASK];
    endfunction

    function automatic logic entry_level(input logic [63:0] e);
        return e[BIT_LEVEL];
    endfunction

    function automatic logic entry_deliverable(input logic [63:0] e);
        return !e[BIT_MASK] && !e[BIT_LOGIC] && (e[DLV_LSB +: 3] == 3'b000);
    endfunction

    function automatic irq_msg_t entry_msg(input logic [63:0] e);
        irq_msg_t m;
        m.vector = e[7:0];
        m.dest   = e[DEST_LSB +: 8];
        return m;
    endfunction

endpackage

// File: rtl/irq_redir_regs.sv
module irq_redir_regs
    import irq_redir_pkg::*;
#(
    parameter int NUM_PINS = 16,
    parameter int OFFS_W   = 8
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           bus_valid,
    input  logic                           bus_we,
    input  logic [OFFS_W-1:0]              bus_addr,
    input  logic [2:0]                     bus_size,
    input  logic [31:0]                    bus_wdata,
    output logic [31:0]                    bus_rdata,
    output logic                           bus_rvalid,
    output logic [NUM_PINS-1:0][63:0]      entries,
    output logic [NUM_PINS-1:0]            entry_wr
);
    localparam int ENT_W     = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1;
    localparam int TBL_SPAN  = 2 * NUM_PINS;
    localparam logic [31:0] VERS_VAL = (32'(NUM_PINS) << 16) | 32'(VERS_CODE);

    logic [31:0]          index_q;
    logic [IDENT_W-1:0]   ident_q;
    logic [NUM_PINS-1:0][63:0] tbl_q;
    logic [NUM_PINS-1:0]  wr_q;

    logic        acc_ok, hit_index, hit_window;
    logic [7:0]  widx;
    logic [7:0]  tidx;
    logic        in_tbl;
    logic [ENT_W-1:0] ent;
    logic        upper;
    logic [31:0] win_rd, rd_val;

    assign acc_ok     = bus_valid && (bus_size == 3'(ACC_BYTES));
    assign hit_index  = acc_ok && (bus_addr == OFFS_W'(OFFS_INDEX));
    assign hit_window = acc_ok && (bus_addr == OFFS_W'(OFFS_WINDOW));
    assign widx       = index_q[7:0];
    assign tidx       = widx - IDX_TBASE;
    assign in_tbl     = (widx >= IDX_TBASE) && (32'(tidx) < TBL_SPAN);
    assign ent        = ENT_W'(tidx >> 1);
    assign upper      = tidx[0];

    always_comb begin
        win_rd = '0;
        if (widx == IDX_IDENT || widx == IDX_ARBW)
            win_rd[IDENT_LSB +: IDENT_W] = ident_q;
        else if (widx == IDX_VERS)
            win_rd = VERS_VAL;
        else if (in_tbl)
            win_rd = upper ? tbl_q[ent][63:32] : tbl_q[ent][31:0];
    end

    always_comb begin
        rd_val = '0;
        if (hit_index)       rd_val = index_q;
        else if (hit_window) rd_val = win_rd;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            index_q    <= '0;
            ident_q    <= '0;
            wr_q       <= '0;
            bus_rdata  <= '0;
            bus_rvalid <= 1'b0;
            for (int i = 0; i < NUM_PINS; i++) tbl_q[i] <= ENTRY_RESET;
        end else begin
            wr_q       <= '0;
            bus_rvalid <= bus_valid && !bus_we;
            if (bus_valid && !bus_we) bus_rdata <= rd_val;
            if (bus_we && hit_index) index_q <= bus_wdata;
            if (bus_we && hit_window) begin
                if (widx == IDX_IDENT)
                    ident_q <= bus_wdata[IDENT_LSB +: IDENT_W];
                else if (in_tbl) begin
                    if (upper) tbl_q[ent][63:32] <= bus_wdata;
                    else       tbl_q[ent][31:0]  <= bus_wdata;
                    wr_q[ent] <= 1'b1;
                end
            end
        end
    end

    assign entries  = tbl_q;
    assign entry_wr = wr_q;

    // R3: the index register moves only on a valid 4-byte write to offset 0x00
    p_index_hold_r3: assert property (@(posedge clk) disable iff (rst)
        !(bus_valid && bus_we && hit_index) |=> $stable(index_q));

    // R2: read data is flagged valid only in the cycle after a read request
    p_rvalid_after_read_r2: assert property (@(posedge clk) disable iff (rst)
        bus_rvalid |-> $past(bus_valid && !bus_we));

endmodule

// File: rtl/irq_redir_pin.sv
module irq_redir_pin
    import irq_redir_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        level_in,
    input  logic [63:0] entry,
    input  logic        entry_wr,
    input  logic        grant,
    output logic        req,
    output irq_msg_t    msg
);
    logic     level_q, pend_q, req_q;
    irq_msg_t msg_q;
    logic     rise, can_send, replay, fire;

    assign rise     = level_in && !level_q;
    assign can_send = entry_deliverable(entry);
    assign replay   = entry_wr && pend_q && !entry_masked(entry);
    assign fire     = (rise && can_send) || (replay && level_in && can_send);

    always_ff @(posedge clk) begin
        if (rst) begin
            level_q <= 1'b0;
            pend_q  <= 1'b0;
            req_q   <= 1'b0;
            msg_q   <= '0;
        end else begin
            level_q <= level_in;
            if (replay)
                pend_q <= 1'b0;
            else if (rise && entry_masked(entry) && entry_level(entry))
                pend_q <= 1'b1;
            if (fire) begin
                req_q <= 1'b1;
                msg_q <= entry_msg(entry);
            end else if (grant) begin
                req_q <= 1'b0;
            end
        end
    end

    assign req = req_q;
    assign msg = msg_q;

    // R7: a rise on a deliverable entry raises a request on the next cycle
    p_rise_requests_r7: assert property (@(posedge clk) disable iff (rst)
        (level_in && !level_q && entry_deliverable(entry)) |=> req);

    // R9: a rise on a masked level-triggered entry records a pending event
    p_masked_level_pends_r9: assert property (@(posedge clk) disable iff (rst)
        (level_in && !level_q && entry_masked(entry) && entry_level(entry)) |=> pend_q);

endmodule

// File: rtl/irq_redir_arb.sv
module irq_redir_arb
    import irq_redir_pkg::*;
#(
    parameter int NUM_PINS = 16
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic [NUM_PINS-1:0]          req,
    input  irq_msg_t [NUM_PINS-1:0]      msgs,
    output logic [NUM_PINS-1:0]          grant,
    input  logic                         msg_ready,
    output logic                         msg_valid,
    output irq_msg_t                     msg_out,
    output logic                         msg_bcast
);
    logic     slot_v, slot_bc;
    irq_msg_t slot_m;
    logic     load;
    irq_msg_t pick_m;

    // lowest-numbered requester wins
    always_comb begin
        grant  = '0;
        pick_m = '0;
        for (int i = NUM_PINS - 1; i >= 0; i--) begin
            if (req[i]) begin
                grant  = '0;
                grant[i] = 1'b1;
                pick_m = msgs[i];
            end
        end
        if (!load) grant = '0;
    end

    assign load = (!slot_v || msg_ready) && (|req);

    always_ff @(posedge clk) begin
        if (rst) begin
            slot_v  <= 1'b0;
            slot_bc <= 1'b0;
            slot_m  <= '0;
        end else if (load) begin
            slot_v  <= 1'b1;
            slot_m  <= pick_m;
            slot_bc <= (pick_m.dest == BCAST_DEST);
        end else if (msg_ready) begin
            slot_v  <= 1'b0;
        end
    end

    assign msg_valid = slot_v;
    assign msg_out   = slot_m;
    assign msg_bcast = slot_bc;

    // R11: an offered message holds until accepted
    p_hold_until_ready_r11: assert property (@(posedge clk) disable iff (rst)
        (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_out) && $stable(msg_bcast)));

    // R11: at most one input is granted per cycle
    p_single_grant_r11: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant));

endmodule

// File: rtl/irq_redir_ctrl.sv
module irq_redir_ctrl
    import irq_redir_pkg::*;
#(
    parameter int NUM_PINS = 16,
    parameter int OFFS_W   = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 bus_valid,
    input  logic                 bus_we,
    input  logic [OFFS_W-1:0]    bus_addr,
    input  logic [2:0]           bus_size,
    input  logic [31:0]          bus_wdata,
    output logic [31:0]          bus_rdata,
    output logic                 bus_rvalid,
    input  logic [NUM_PINS-1:0]  irq_in,
    output logic                 msg_valid,
    input  logic                 msg_ready,
    output logic [7:0]           msg_vector,
    output logic [7:0]           msg_dest,
    output logic                 msg_bcast
);
    logic [NUM_PINS-1:0][63:0] entries;
    logic [NUM_PINS-1:0]       entry_wr;
    logic [NUM_PINS-1:0]       req;
    logic [NUM_PINS-1:0]       grant;
    irq_msg_t [NUM_PINS-1:0]   msgs;
    irq_msg_t                  msg_out;

    irq_redir_regs #(.NUM_PINS(NUM_PINS), .OFFS_W(OFFS_W)) u_regs (
        .clk        (clk),
        .rst        (rst),
        .bus_valid  (bus_valid),
        .bus_we     (bus_we),
        .bus_addr   (bus_addr),
        .bus_size   (bus_size),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .bus_rvalid (bus_rvalid),
        .entries    (entries),
        .entry_wr   (entry_wr)
    );

    for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
        irq_redir_pin u_pin (
            .clk      (clk),
            .rst      (rst),
            .level_in (irq_in[g]),
            .entry    (entries[g]),
            .entry_wr (entry_wr[g]),
            .grant    (grant[g]),
            .req      (req[g]),
            .msg      (msgs[g])
        );
    end

    irq_redir_arb #(.NUM_PINS(NUM_PINS)) u_arb (
        .clk       (clk),
        .rst       (rst),
        .req       (req),
        .msgs      (msgs),
        .grant     (grant),
        .msg_ready (msg_ready),
        .msg_valid (msg_valid),
        .msg_out   (msg_out),
        .msg_bcast (msg_bcast)
    );

    assign msg_vector = msg_out.vector;
    assign msg_dest   = msg_out.dest;

endmodule

// File: tb/irq_redir_ctrl_tb.sv
module irq_redir_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_valid = 1'b0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [2:0]  bus_size = 3'd4;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_rvalid;
    logic [15:0] irq_in = '0;
    logic        msg_valid;
    logic        msg_ready = 1'b0;
    logic [7:0]  msg_vector, msg_dest;
    logic        msg_bcast;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    irq_redir_ctrl u_dut (
        .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_size(bus_size), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid), .irq_in(irq_in),
        .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_vector(msg_vector),
        .msg_dest(msg_dest), .msg_bcast(msg_bcast)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [7:0] off, input logic [2:0] sz, input logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_we = 1'b1; bus_addr = off; bus_size = sz; bus_wdata = d;
        @(negedge clk);
        bus_valid = 1'b0; bus_we = 1'b0; bus_size = 3'd4;
    endtask

    task automatic bus_rd(input logic [7:0] off, input logic [2:0] sz, output logic [31:0] d,
                          output logic rv);
        @(negedge clk);
        bus_valid = 1'b1; bus_we = 1'b0; bus_addr = off; bus_size = sz;
        @(negedge clk);
        bus_valid = 1'b0; bus_size = 3'd4;
        d = bus_rdata; rv = bus_rvalid;
    endtask

    task automatic win_wr(input logic [7:0] idx, input logic [31:0] d);
        bus_wr(8'h00, 3'd4, {24'h0, idx});
        bus_wr(8'h10, 3'd4, d);
    endtask

    task automatic win_rd(input logic [7:0] idx, output logic [31:0] d);
        logic rv;
        bus_wr(8'h00, 3'd4, {24'h0, idx});
        bus_rd(8'h10, 3'd4, d, rv);
    endtask

    task automatic set_entry(input int pin, input logic [63:0] e);
        win_wr(8'(8'h10 + 2 * pin + 1), e[63:32]);
        win_wr(8'(8'h10 + 2 * pin), e[31:0]);
    endtask

    // wait for a message, accept it; got=0 if none within n cycles
    task automatic take_msg(input int n, output logic got, output logic [7:0] vec,
                            output logic [7:0] dst, output logic bc);
        got = 1'b0; vec = '0; dst = '0; bc = 1'b0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (msg_valid) begin
                got = 1'b1; vec = msg_vector; dst = msg_dest; bc = msg_bcast;
                msg_ready = 1'b1;
                @(negedge clk);
                msg_ready = 1'b0;
                break;
            end
        end
    endtask

    task automatic expect_none(input string req, input int n);
        logic seen = 1'b0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (msg_valid) seen = 1'b1;
        end
        check(req, 32'(seen), 32'd0);
    endtask

    task automatic t_reset;
        logic [31:0] d; logic rv;
        check("R1 msg_valid", 32'(msg_valid), 32'd0);
        bus_rd(8'h00, 3'd4, d, rv);
        check("R1 index", d, 32'h0);
        check("R2 rvalid", 32'(rv), 32'd1);
        win_rd(8'h10, d); check("R1 entry0 low", d, 32'h0001_0000);
        win_rd(8'h2F, d); check("R1 entry15 high", d, 32'h0001_0000);
    endtask

    task automatic t_decode;
        logic [31:0] d; logic rv;
        bus_wr(8'h00, 3'd4, 32'hABCD_0002);
        bus_rd(8'h00, 3'd4, d, rv); check("R3 index readback", d, 32'hABCD_0002);
        win_rd(8'h00, d); check("R3 low byte decode", d, 32'h0);
        bus_wr(8'h00, 3'd4, 32'h1234_5600);
        win_rd(8'h00, d); check("R3 low byte selects ident", d, 32'h0);
        bus_wr(8'h04, 3'd4, 32'h0000_0001);
        bus_rd(8'h00, 3'd4, d, rv); check("R2 bad offset write ignored", d, 32'h0);
        bus_rd(8'h04, 3'd4, d, rv); check("R2 bad offset reads 0", d, 32'h0);
        bus_rd(8'h00, 3'd2, d, rv); check("R2 bad size reads 0", d, 32'h0);
        bus_wr(8'h10, 3'd1, 32'hFFFF_FFFF);
        win_rd(8'h00, d); check("R2 bad size write ignored", d, 32'h0);
    endtask

    task automatic t_ident_vers;
        logic [31:0] d;
        win_wr(8'h00, 32'hFFFF_FFFF);
        win_rd(8'h00, d); check("R4 ident field", d, 32'h0F00_0000);
        win_rd(8'h02, d); check("R4 arb mirrors ident", d, 32'h0F00_0000);
        win_wr(8'h02, 32'h0);
        win_rd(8'h02, d); check("R4 arb write ignored", d, 32'h0F00_0000);
        win_rd(8'h01, d); check("R5 version", d, 32'h0010_0011);
        win_wr(8'h01, 32'h0);
        win_rd(8'h01, d); check("R5 version write ignored", d, 32'h0010_0011);
    endtask

    task automatic t_table;
        logic [31:0] d;
        win_wr(8'h1F, 32'hA5A5_0000);
        win_rd(8'h1F, d); check("R6 high half", d, 32'hA5A5_0000);
        win_rd(8'h1E, d); check("R6 low half kept", d, 32'h0001_0000);
        win_wr(8'h1E, 32'h0001_1234);
        win_rd(8'h1F, d); check("R6 high half kept", d, 32'hA5A5_0000);
        win_rd(8'h30, d); check("R6 above table", d, 32'h0);
        win_rd(8'h0F, d); check("R6 below table", d, 32'h0);
        set_entry(7, 64'h0001_0000_0001_0000);
    endtask

    task automatic t_deliver;
        logic g; logic [7:0] v, ds; logic b;
        set_entry(0, 64'h0700_0000_0000_0031);
        @(negedge clk); irq_in[0] = 1'b1;
        take_msg(10, g, v, ds, b);
        check("R7 message sent", 32'(g), 32'd1);
        check("R7 vector", 32'(v), 32'h31);
        check("R7 dest", 32'(ds), 32'h07);
        check("R8 no bcast", 32'(b), 32'd0);
        @(negedge clk); irq_in[0] = 1'b0;
        expect_none("R7 fall sends nothing", 6);
        set_entry(1, 64'hFF00_0000_0000_0020);
        @(negedge clk); irq_in[1] = 1'b1;
        take_msg(10, g, v, ds, b);
        check("R8 bcast vector", 32'(v), 32'h20);
        check("R8 bcast dest", 32'(ds), 32'hFF);
        check("R8 bcast flag", 32'(b), 32'd1);
        @(negedge clk); irq_in[1] = 1'b0;
    endtask

    task automatic t_pending;
        logic g; logic [7:0] v, ds; logic b;
        set_entry(2, 64'h0300_0000_0001_8042);
        @(negedge clk); irq_in[2] = 1'b1;
        expect_none("R9 masked level no send", 6);
        win_wr(8'h14, 32'h0000_8042);
        take_msg(10, g, v, ds, b);
        check("R9 replay sent", 32'(g), 32'd1);
        check("R9 replay vector", 32'(v), 32'h42);
        check("R9 replay dest", 32'(ds), 32'h03);
        @(negedge clk); irq_in[2] = 1'b0;
        win_wr(8'h14, 32'h0001_8042);
        @(negedge clk); irq_in[2] = 1'b1;
        @(negedge clk); irq_in[2] = 1'b0;
        win_wr(8'h14, 32'h0000_8042);
        expect_none("R9 replay dropped when low", 8);
    endtask

    task automatic t_edge_masked;
        set_entry(6, 64'h0100_0000_0001_0066);
        @(negedge clk); irq_in[6] = 1'b1;
        expect_none("R10 masked edge no send", 6);
        win_wr(8'h1C, 32'h0000_0066);
        expect_none("R10 unmask no replay", 8);
        @(negedge clk); irq_in[6] = 1'b0;
    endtask

    task automatic t_priority;
        logic g; logic [7:0] v, ds; logic b;
        set_entry(3, 64'h0000_0000_0000_0033);
        set_entry(5, 64'h0000_0000_0000_0035);
        @(negedge clk); irq_in[3] = 1'b1; irq_in[5] = 1'b1;
        repeat (4) @(negedge clk);
        check("R11 offered", 32'(msg_valid), 32'd1);
        check("R11 lowest first", 32'(msg_vector), 32'h33);
        repeat (3) @(negedge clk);
        check("R11 held stable", 32'(msg_vector), 32'h33);
        take_msg(2, g, v, ds, b);
        take_msg(10, g, v, ds, b);
        check("R11 second sent", 32'(g), 32'd1);
        check("R11 second vector", 32'(v), 32'h35);
        @(negedge clk); irq_in[3] = 1'b0; irq_in[5] = 1'b0;
    endtask

    task automatic t_modes;
        set_entry(4, 64'h0000_0000_0000_0855);
        @(negedge clk); irq_in[4] = 1'b1;
        expect_none("R12 logical mode", 6);
        @(negedge clk); irq_in[4] = 1'b0;
        set_entry(4, 64'h0000_0000_0000_0155);
        @(negedge clk); irq_in[4] = 1'b1;
        expect_none("R12 nonfixed delivery", 6);
        @(negedge clk); irq_in[4] = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_decode();
        t_ident_vers();
        t_table();
        t_deliver();
        t_pending();
        t_edge_masked();
        t_priority();
        t_modes();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                errors++;
                checks++;
                $display("FAIL watchdog actual=0x0 expected=0x1");
            end
        join_any
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule